// File: doc/BRIEF.md
# Link Reset and Link-Up Supervisor

This block runs the bring-up of one root-port link. On a start request it pulls all three endpoint reset-control bits low, holds them there for a fixed number of microsecond ticks, and then raises only the reset-output bit. After a second, longer settle interval it probes the data-link-active status bit once per poll interval. The first probe that finds the bit set ends the sequence with `link_up`. If a fixed number of probes all find it clear, the sequence ends with `link_fail`.

Time is measured only in pulses of `us_tick`, so the clock frequency does not matter. The hold time, settle time, poll interval and probe budget are parameters. Their defaults are 250 µs, 100 ms, 1 ms and 1000 probes. The reset-control output feeds the port's reset pins. The status vector is the link-status word: bit 2 is data-link-active and bit 3 is physical-link-up.

Top module: `lrs_supervisor`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `perst_ctl` is 3'b000 and both `link_up` and `link_fail` are 0.
- R2: A `start` sampled while the block is idle or finished has this effect at the next edge: `perst_ctl` becomes 3'b000 (bit 2 source select, bit 1 endpoint-mode reset and bit 0 reset output all cleared) and both result outputs drop to 0.
- R3: `perst_ctl` stays 3'b000 until the edge that samples the HOLD_US-th `us_tick` after the start. At that edge it becomes 3'b001, which sets only bit 0.
- R4: The status input is not looked at during the hold or settle intervals. The first probe happens in the cycle after the edge that samples the SETTLE_US-th tick after release.
- R5: A probe tests only bit 2 of `link_stat`. If that bit is 1, `link_up` rises at the edge that ends the probe cycle. Bits 0, 1 and 3 have no effect.
- R6: After a probe that misses, the next probe comes in the cycle after POLL_US further ticks. A tick during a probe cycle is not counted. When the POLL_MAX-th probe misses, `link_fail` rises at the edge that ends that probe cycle.
- R7: `link_up` and `link_fail` are never high together. Each one stays high until a start is accepted.
- R8: A `start` that arrives during the hold, settle or poll phase is ignored, and the timing of the sequence is unchanged.
- R9: Cycles without `us_tick` do not advance any interval, so the sequence stalls in its current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Request to run the reset and link-up sequence |
| link_stat | input | 4 | Link status; bit 2 data-link-active, bit 3 physical-link-up |
| perst_ctl | output | 3 | Reset control; bit 2 source select, bit 1 endpoint-mode reset, bit 0 reset output |
| link_up | output | 1 | Sequence ended with the link active |
| link_fail | output | 1 | Probe budget ran out with the link down |

## Verification
Each result is due a fixed number of edges after its cause:
- The cleared reset bits appear one edge after an accepted start.
- The release appears at the edge that samples the last hold tick.
- A probe takes place one cycle after the last settle or poll tick.
- `link_up` or `link_fail` appears at the edge that closes the deciding probe cycle.

The bench keeps a behavioural model that counts down the remaining ticks and probes. It samples every output at the falling edge between updates, so each expected value is compared in exactly the cycle it is due. The stimulus includes several tick rates, a long stall with no ticks, starts arriving mid-sequence, and status words that set every bit except bit 2.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_SETTLE,
        PH_POLL,
        PH_UP,
        PH_DOWN
    } lrs_phase_e;

    localparam int CTL_W   = 3;
    localparam int STAT_W  = 4;
    localparam int DL_BIT  = 2;
    localparam int PHY_BIT = 3;

    localparam logic [CTL_W-1:0] CTL_ASSERTED = 3'b000;
    localparam logic [CTL_W-1:0] CTL_RELEASED = 3'b001;

    typedef struct packed {
        logic up;
        logic fail;
    } lrs_result_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic phase_accepts_start(input lrs_phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_UP) || (ph == PH_DOWN);
    endfunction

endpackage

// File: rtl/lrs_interval.sv
module lrs_interval #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = tick && (cnt == (limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lrs_budget.sv
module lrs_budget #(
    parameter int MAX = 4,
    parameter int W   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic last
);
    logic [W-1:0] tries;

    assign last = (tries == W'(MAX - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tries <= '0;
        end else if (miss && !last) begin
            tries <= tries + 1'b1;
        end
    end
endmodule

// File: rtl/lrs_supervisor.sv
module lrs_supervisor
    import lrs_pkg::*;
#(
    parameter int HOLD_US   = 250,
    parameter int SETTLE_US = 100000,
    parameter int POLL_US   = 1000,
    parameter int POLL_MAX  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              start,
    input  logic [STAT_W-1:0] link_stat,
    output logic [CTL_W-1:0]  perst_ctl,
    output logic              link_up,
    output logic              link_fail
);
    localparam int CNT_W = $clog2(max3(HOLD_US, SETTLE_US, POLL_US) + 1);
    localparam int TRY_W = $clog2(POLL_MAX + 1);

    localparam logic [CNT_W-1:0] LIM_HOLD   = CNT_W'(HOLD_US);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_US);
    localparam logic [CNT_W-1:0] LIM_POLL   = CNT_W'(POLL_US);

    lrs_phase_e        ph;
    lrs_result_t       res;
    logic [CTL_W-1:0]  ctl;
    logic              probe;
    logic              accept;
    logic              dl_active;
    logic              tick_en;
    logic              hit;
    logic              last;
    logic              miss;
    logic [CNT_W-1:0]  limit;
    logic              unused_stat;

    assign dl_active   = link_stat[DL_BIT];
    assign unused_stat = ^{link_stat[PHY_BIT], link_stat[1:0]};
    assign accept      = start && phase_accepts_start(ph);
    assign miss        = (ph == PH_POLL) && probe && !dl_active;

    always_comb begin
        unique case (ph)
            PH_HOLD:   tick_en = us_tick;
            PH_SETTLE: tick_en = us_tick;
            PH_POLL:   tick_en = us_tick && !probe;
            default:   tick_en = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ph)
            PH_HOLD:   limit = LIM_HOLD;
            PH_SETTLE: limit = LIM_SETTLE;
            default:   limit = LIM_POLL;
        endcase
    end

    lrs_interval #(.W(CNT_W)) u_interval (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .tick  (tick_en),
        .limit (limit),
        .hit   (hit)
    );

    lrs_budget #(.MAX(POLL_MAX), .W(TRY_W)) u_budget (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .miss (miss),
        .last (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            ctl   <= CTL_ASSERTED;
            res   <= '0;
            probe <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE, PH_UP, PH_DOWN: begin
                    if (start) begin
                        ph    <= PH_HOLD;
                        ctl   <= CTL_ASSERTED;
                        res   <= '0;
                        probe <= 1'b0;
                    end
                end
                PH_HOLD: begin
                    if (hit) begin
                        ph  <= PH_SETTLE;
                        ctl <= CTL_RELEASED;
                    end
                end
                PH_SETTLE: begin
                    if (hit) begin
                        ph    <= PH_POLL;
                        probe <= 1'b1;
                    end
                end
                PH_POLL: begin
                    if (probe) begin
                        probe <= 1'b0;
                        if (dl_active) begin
                            ph     <= PH_UP;
                            res.up <= 1'b1;
                        end else if (last) begin
                            ph       <= PH_DOWN;
                            res.fail <= 1'b1;
                        end
                    end else if (hit) begin
                        probe <= 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign perst_ctl = ctl;
    assign link_up   = res.up;
    assign link_fail = res.fail;
endmodule

// File: rtl/lrs_supervisor_chk.sv
module lrs_supervisor_chk
    import lrs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             us_tick,
    input logic             start,
    input logic [3:0]       link_stat,
    input logic [2:0]       perst_ctl,
    input logic             link_up,
    input logic             link_fail,
    input lrs_phase_e       ph
);
    // R2
    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (start && (ph == PH_IDLE || ph == PH_UP || ph == PH_DOWN))
        |=> (perst_ctl == 3'b000 && !link_up && !link_fail && ph == PH_HOLD));

    // R3
    p_release_from_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(perst_ctl[0]) |-> ($past(ph) == PH_HOLD && $past(us_tick)));

    // R4
    p_no_early_up_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SETTLE) |=> !link_up);

    // R5
    p_up_needs_dl_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> ($past(link_stat[2]) && $past(ph) == PH_POLL));

    // R6
    p_fail_needs_miss_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(link_fail) |-> (!$past(link_stat[2]) && $past(ph) == PH_POLL));

    // R7
    p_mutex_r7: assert property (@(posedge clk) disable iff (rst)
        !(link_up && link_fail));

    p_keep_up_r7: assert property (@(posedge clk) disable iff (rst)
        (link_up && !start) |=> link_up);

    p_keep_fail_r7: assert property (@(posedge clk) disable iff (rst)
        (link_fail && !start) |=> link_fail);

    // R8
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (start && ph == PH_SETTLE) |=> perst_ctl[0]);

    // R9
    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HOLD && !us_tick) |=> (ph == PH_HOLD && perst_ctl == 3'b000));
endmodule

bind lrs_supervisor lrs_supervisor_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .us_tick   (us_tick),
    .start     (start),
    .link_stat (link_stat),
    .perst_ctl (perst_ctl),
    .link_up   (link_up),
    .link_fail (link_fail),
    .ph        (ph)
);

// File: tb/tb_lrs_supervisor.sv
module tb_lrs_supervisor;
    localparam int HOLD   = 4;
    localparam int SETTLE = 6;
    localparam int POLL   = 3;
    localparam int PMAX   = 5;
    localparam int WDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       start = 1'b0;
    logic [3:0] link_stat = 4'h0;
    logic [2:0] perst_ctl;
    logic       link_up;
    logic       link_fail;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tick_div = 1;

    // behavioural model: 0 idle, 1 hold, 2 settle, 3 poll, 4 up, 5 down
    int         m_ph = 0;
    int         m_left = 0;
    int         m_miss = 0;
    bit         m_probe = 0;
    logic [2:0] m_ctl = 3'b000;
    bit         m_up = 0;
    bit         m_fail = 0;

    always #2 clk = ~clk;

    lrs_supervisor #(
        .HOLD_US(HOLD), .SETTLE_US(SETTLE), .POLL_US(POLL), .POLL_MAX(PMAX)
    ) dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .start(start),
        .link_stat(link_stat), .perst_ctl(perst_ctl),
        .link_up(link_up), .link_fail(link_fail)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: got cycle %0d expected below %0d", cyc, WDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (rst) begin
            m_ph = 0; m_ctl = 3'b000; m_up = 0; m_fail = 0; m_probe = 0;
        end else begin
            case (m_ph)
                0, 4, 5: if (start) begin
                    m_ph = 1; m_ctl = 3'b000; m_up = 0; m_fail = 0;
                    m_left = HOLD; m_probe = 0;
                end
                1: if (us_tick) begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin m_ph = 2; m_ctl = 3'b001; m_left = SETTLE; end
                end
                2: if (us_tick) begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin m_ph = 3; m_probe = 1; m_miss = 0; end
                end
                3: if (m_probe) begin
                    if (link_stat[2]) begin
                        m_ph = 4; m_up = 1; m_probe = 0;
                    end else begin
                        m_miss = m_miss + 1;
                        m_probe = 0;
                        m_left = POLL;
                        if (m_miss == PMAX) begin m_ph = 5; m_fail = 1; end
                    end
                end else if (us_tick) begin
                    m_left = m_left - 1;
                    if (m_left == 0) m_probe = 1;
                end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic compare_all();
        check("R1/R2/R3 perst_ctl vs model", 32'(perst_ctl), 32'(m_ctl));
        check("R5/R7/R8 link_up vs model", 32'(link_up), 32'(m_up));
        check("R6/R7/R8 link_fail vs model", 32'(link_fail), 32'(m_fail));
    endtask

    task automatic cycle(input bit s, input logic [3:0] st);
        @(negedge clk);
        compare_all();
        start     = s;
        link_stat = st;
        us_tick   = (tick_div != 0) && ((cyc % (tick_div == 0 ? 1 : tick_div)) == 0);
    endtask

    task automatic idle(input int n, input logic [3:0] st);
        for (int i = 0; i < n; i++) cycle(1'b0, st);
    endtask

    task automatic kick(input logic [3:0] st);
        cycle(1'b1, st);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 perst_ctl in reset", 32'(perst_ctl), 32'h0);
        check("R1 link_up in reset", 32'(link_up), 32'h0);
        check("R1 link_fail in reset", 32'(link_fail), 32'h0);
        rst = 1'b0;
        idle(3, 4'h0);

        // R5: link comes up after some misses
        kick(4'h0);
        idle(1, 4'h0);
        check("R2 reset bits cleared after start", 32'(perst_ctl), 32'h0);
        idle(14, 4'h0);
        check("R3 only bit 0 set after hold", 32'(perst_ctl), 32'h1);
        idle(20, 4'b0100);
        check("R5 link_up after active probe", 32'(link_up), 32'h1);

        // R7: result holds when status drops
        idle(10, 4'h0);
        check("R7 link_up held", 32'(link_up), 32'h1);
        check("R7 link_fail stays low", 32'(link_fail), 32'h0);

        // R8 and R6: start mid-run ignored, bit 3 alone never counts
        kick(4'b1011);
        idle(1, 4'b1011);
        check("R2 link_up cleared on start", 32'(link_up), 32'h0);
        idle(5, 4'b1011);
        kick(4'b1011);
        idle(45, 4'b1011);
        check("R6 link_fail after budget", 32'(link_fail), 32'h1);
        check("R5 bits other than 2 ignored", 32'(link_up), 32'h0);

        // R9 and R4: ticks stop during hold, status active early
        kick(4'b0100);
        idle(2, 4'b0100);
        tick_div = 0;
        idle(30, 4'b0100);
        check("R9 hold stalls without ticks", 32'(perst_ctl), 32'h0);
        tick_div = 3;
        idle(12, 4'b0100);
        check("R3 released after hold ticks", 32'(perst_ctl), 32'h1);
        check("R4 no probe during settle", 32'(link_up), 32'h0);
        idle(40, 4'b0100);
        check("R4 link_up at first probe", 32'(link_up), 32'h1);

        // R6/R7: toggling status, tick every other cycle
        tick_div = 2;
        kick(4'h0);
        for (int i = 0; i < 80; i++) cycle(1'b0, {1'b0, (i % 7 == 3), 2'b00});
        check("R7 exactly one result", 32'(link_up + link_fail), 32'h1);
        idle(2, 4'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule